// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts which earlier store a load (or store) in an out-of-order core must wait for. An identifier table, indexed by instruction address, maps each trained instruction to a store-set number. A second table, one entry per set, records the sequence number of the most recently fetched store of that set. When a load is about to be scheduled, the core presents its PC on the lookup port. The block answers with the sequence number of the store it must wait behind, or zero when no dependence is predicted.

Training happens when the core detects a memory-order violation and presents the offending store PC and load PC. Stores are registered as they are fetched. They are retired from the per-set table when they issue. Squashes and a global clear drop recorded stores. The core's load/store queue, replay and wake-up logic sit outside this block.

All updates are registered on the rising clock edge. At most one update takes effect per cycle, chosen by a fixed priority. The lookup is purely combinational.

Top module: `store_set_pred`

## Requirements
- R1: An instruction's identifier-table index is its PC shifted right by 2 and masked to log2(ID_ENTRIES) bits. PCs that differ only above those bits, or in bits [1:0], share an entry. ID_ENTRIES is a power of two.
- R2: On a violation where neither entry is valid, both the load and the store entries become valid with a new set number. That number is the low log2(SET_ENTRIES) bits of the load's index, and the set's counter rises by one.
- R3: On a violation where only the load's entry is valid, the store's entry takes the load's set number, and that set's counter rises by one.
- R4: On a violation where only the store's entry is valid, the load's entry takes the store's set number, and no counter changes.
- R5: On a violation where both entries are valid, the instruction in the set with the smaller counter moves into the other set. The receiving counter rises by one and the losing counter falls by one, never below zero. When the counters are equal, the load moves into the store's set.
- R6: A store insert whose identifier entry is invalid changes nothing. Otherwise it writes its sequence number into its set's last-store entry and marks that entry valid.
- R7: Lookup returns 0 when the PC's identifier entry is invalid or when its set's last-store entry is invalid. Otherwise it returns the recorded sequence number, in the same cycle.
- R8: An issue notice with is_store low has no effect. A store issue invalidates its set's last-store entry only when that entry is valid and holds exactly the issuing sequence number.
- R9: A squash with value N invalidates every valid last-store entry whose recorded sequence number is strictly less than N.
- R10: Clear invalidates every identifier entry and every last-store entry, and leaves the set counters unchanged.
- R11: Requests presented in the same cycle are resolved by priority: clear, then squash, then violation, then insert, then issue. Only the highest one takes effect, and the others are dropped.
- R12: After reset every entry of both tables is invalid and every counter is zero, so every lookup returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol_valid | input | 1 | Violation training request |
| viol_store_pc | input | PC_W | PC of the violating store |
| viol_load_pc | input | PC_W | PC of the violating load |
| ins_valid | input | 1 | Fetched-store insert request |
| ins_pc | input | PC_W | PC of the inserted store |
| ins_seq | input | SEQ_W | Sequence number of the inserted store |
| lkp_pc | input | PC_W | PC to look up |
| lkp_seq | output | SEQ_W | Predicted producer store sequence number, 0 if none |
| iss_valid | input | 1 | Issue notice |
| iss_is_store | input | 1 | The issuing instruction is a store |
| iss_pc | input | PC_W | PC of the issuing instruction |
| iss_seq | input | SEQ_W | Sequence number of the issuing instruction |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary sequence number |
| clr | input | 1 | Global clear of both tables |

## Verification
Two pairs of requests are driven in the same cycle. In the first, an insert and an exact-match store issue arrive together for the same set. In the second, a squash and an insert arrive together. A clear is also presented together with an insert. In each case the winner is judged through the lookup port in the following cycle. For the insert plus issue pair, the inserted sequence number must still be visible, because the insert wins. For the squash plus insert pair, the entry must read back as 0, because the squash wins and the insert is dropped.

// File: rtl/store_set_pred.sv
module store_set_pred #(
  parameter int PC_W        = 16,
  parameter int SEQ_W       = 8,
  parameter int ID_ENTRIES  = 16,
  parameter int SET_ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_store_pc,
  input  logic [PC_W-1:0]  viol_load_pc,
  input  logic             ins_valid,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  lkp_pc,
  output logic [SEQ_W-1:0] lkp_seq,
  input  logic             iss_valid,
  input  logic             iss_is_store,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             clr
);
  localparam int IW = $clog2(ID_ENTRIES);
  localparam int SW = $clog2(SET_ENTRIES);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [ID_ENTRIES-1:0]               id_v;
  logic [ID_ENTRIES-1:0][SW-1:0]       id_set;
  logic [SET_ENTRIES-1:0]              last_v;
  logic [SET_ENTRIES-1:0][SEQ_W-1:0]   last_seq;
  logic [SET_ENTRIES-1:0][CW-1:0]      cnt;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{viol_store_pc, viol_load_pc, ins_pc, lkp_pc, iss_pc};

  logic [IW-1:0] li, si, ii, xi, ki;
  assign li = viol_load_pc[IW+1:2];
  assign si = viol_store_pc[IW+1:2];
  assign ii = ins_pc[IW+1:2];
  assign xi = iss_pc[IW+1:2];
  assign ki = lkp_pc[IW+1:2];

  logic do_sq, do_v, do_ins, do_iss;
  assign do_sq  = sq_valid && !clr;
  assign do_v   = viol_valid && !clr && !sq_valid;
  assign do_ins = ins_valid && !clr && !sq_valid && !viol_valid;
  assign do_iss = iss_valid && iss_is_store && !clr && !sq_valid && !viol_valid && !ins_valid;

  assign lkp_seq = (id_v[ki] && last_v[id_set[ki]]) ? last_seq[id_set[ki]] : '0;

  logic          lv, sv, wr_l, wr_s, inc_en, dec_en;
  logic [SW-1:0] lid, sid, wr_id, inc_id, dec_id;
  assign lv  = id_v[li];
  assign sv  = id_v[si];
  assign lid = id_set[li];
  assign sid = id_set[si];

  always_comb begin
    wr_l = 1'b0; wr_s = 1'b0; inc_en = 1'b0; dec_en = 1'b0;
    wr_id = lid; inc_id = lid; dec_id = sid;
    if (!lv && !sv) begin
      wr_l = 1'b1; wr_s = 1'b1; wr_id = li[SW-1:0];
      inc_en = 1'b1; inc_id = li[SW-1:0];
    end else if (lv && !sv) begin
      wr_s = 1'b1; wr_id = lid; inc_en = 1'b1; inc_id = lid;
    end else if (!lv && sv) begin
      wr_l = 1'b1; wr_id = sid;
    end else if (cnt[lid] > cnt[sid]) begin
      wr_s = 1'b1; wr_id = lid;
      inc_en = 1'b1; inc_id = lid; dec_en = 1'b1; dec_id = sid;
    end else begin
      wr_l = 1'b1; wr_id = sid;
      inc_en = 1'b1; inc_id = sid; dec_en = 1'b1; dec_id = lid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_v     <= '0;
      id_set   <= '0;
      last_v   <= '0;
      last_seq <= '0;
      cnt      <= '0;
    end else if (clr) begin
      id_v   <= '0;
      last_v <= '0;
    end else if (do_sq) begin
      for (int k = 0; k < SET_ENTRIES; k++)
        if (last_v[k] && last_seq[k] < sq_seq) last_v[k] <= 1'b0;
    end else if (do_v) begin
      if (wr_l) begin id_v[li] <= 1'b1; id_set[li] <= wr_id; end
      if (wr_s) begin id_v[si] <= 1'b1; id_set[si] <= wr_id; end
      for (int k = 0; k < SET_ENTRIES; k++) begin
        if (inc_en && inc_id == SW'(k) && !(dec_en && dec_id == SW'(k))) begin
          if (cnt[k] != CMAX) cnt[k] <= cnt[k] + 1'b1;
        end else if (dec_en && dec_id == SW'(k) && !(inc_en && inc_id == SW'(k))) begin
          if (cnt[k] != '0) cnt[k] <= cnt[k] - 1'b1;
        end
      end
    end else if (do_ins) begin
      if (id_v[ii]) begin
        last_v[id_set[ii]]   <= 1'b1;
        last_seq[id_set[ii]] <= ins_seq;
      end
    end else if (do_iss) begin
      if (id_v[xi] && last_v[id_set[xi]] && last_seq[id_set[xi]] == iss_seq)
        last_v[id_set[xi]] <= 1'b0;
    end
  end

  p_viol_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_v |=> id_v[$past(li)] && id_v[$past(si)]);

  p_store_only_keeps_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_v && !lv && sv) |=> $stable(cnt));

  p_insert_records_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ins && id_v[ii]) |=> last_v[$past(id_set[ii])] && last_seq[$past(id_set[ii])] == $past(ins_seq));

  p_nonstore_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_is_store && !clr && !sq_valid && !viol_valid && !ins_valid) |=> $stable(last_v));

  p_squash_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_sq |=> $countones(last_v) <= $past($countones(last_v)));

  p_clear_keeps_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (id_v == '0) && (last_v == '0) && $stable(cnt));
endmodule

// File: tb/sim_store_set_pred.sv
module sim_store_set_pred;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        viol_valid = 0, ins_valid = 0, iss_valid = 0, iss_is_store = 0, sq_valid = 0, clr = 0;
  logic [15:0] viol_store_pc = 0, viol_load_pc = 0, ins_pc = 0, lkp_pc = 0, iss_pc = 0;
  logic [7:0]  ins_seq = 0, iss_seq = 0, sq_seq = 0, lkp_seq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_set_pred u0 (.clk, .rst_n, .viol_valid, .viol_store_pc, .viol_load_pc,
    .ins_valid, .ins_pc, .ins_seq, .lkp_pc, .lkp_seq, .iss_valid, .iss_is_store,
    .iss_pc, .iss_seq, .sq_valid, .sq_seq, .clr);

  task automatic tick();
    @(posedge clk); #2;
    viol_valid = 0; ins_valid = 0; iss_valid = 0; iss_is_store = 0; sq_valid = 0; clr = 0;
  endtask

  task automatic chk(input logic [15:0] pc, input logic [7:0] exp, input string tag);
    lkp_pc = pc; #1;
    checks++;
    if (lkp_seq !== exp) begin
      errors++;
      $display("FAIL %s pc=%h actual=%0d expected=%0d", tag, pc, lkp_seq, exp);
    end
  endtask

  task automatic viol(input logic [15:0] s, input logic [15:0] l);
    viol_valid = 1; viol_store_pc = s; viol_load_pc = l;
  endtask
  task automatic ins(input logic [15:0] pc, input logic [7:0] seq);
    ins_valid = 1; ins_pc = pc; ins_seq = seq;
  endtask
  task automatic iss(input logic [15:0] pc, input logic [7:0] seq, input logic st);
    iss_valid = 1; iss_pc = pc; iss_seq = seq; iss_is_store = st;
  endtask
  task automatic sq(input logic [7:0] n);
    sq_valid = 1; sq_seq = n;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    for (int i = 0; i < 16; i++) chk(16'(i * 4), 8'd0, "R12 reset lookup");

    viol(16'h0008, 16'h0004); tick();          // new set 1 (R2)
    ins(16'h0008, 8'd10); tick();
    chk(16'h0004, 8'd10, "R2 load joined new set");
    chk(16'h0044, 8'd10, "R1 index alias above mask");
    chk(16'h0007, 8'd10, "R1 low offset bits ignored");
    chk(16'h000C, 8'd0,  "R7 invalid id entry");

    ins(16'h000C, 8'd20); tick();
    chk(16'h000C, 8'd0,  "R6 insert without id ignored");
    chk(16'h0004, 8'd10, "R6 other set untouched");

    viol(16'h0010, 16'h0004); tick();          // store idx4 joins set1 (R3)
    ins(16'h0010, 8'd30); tick();
    chk(16'h0004, 8'd30, "R3 store joined load set");

    viol(16'h0010, 16'h0014); tick();          // load idx5 joins set1 (R4)
    chk(16'h0014, 8'd30, "R4 load joined store set");

    iss(16'h0010, 8'd29, 1'b1); tick();
    chk(16'h0004, 8'd30, "R8 mismatched store issue");
    iss(16'h0010, 8'd30, 1'b0); tick();
    chk(16'h0004, 8'd30, "R8 non-store issue ignored");
    iss(16'h0010, 8'd30, 1'b1); tick();
    chk(16'h0004, 8'd0,  "R8 exact store issue clears");

    viol(16'h0028, 16'h0018); tick();          // set 6, count 1
    viol(16'h0028, 16'h0004); tick();          // set1 count 2 > 1: store moves
    ins(16'h0028, 8'd40); tick();
    chk(16'h0004, 8'd40, "R5 store moved to larger set");
    chk(16'h0018, 8'd0,  "R5 smaller set left");

    viol(16'h0030, 16'h001C); tick();          // set 7
    viol(16'h0034, 16'h0020); tick();          // set 0
    viol(16'h0034, 16'h001C); tick();          // tie: load moves to set 0
    ins(16'h0034, 8'd50); tick();
    chk(16'h001C, 8'd50, "R5 tie moves load");
    chk(16'h0030, 8'd0,  "R5 tie store stays");

    sq(8'd50); tick();
    chk(16'h0004, 8'd0,  "R9 older entry squashed");
    chk(16'h001C, 8'd50, "R9 equal entry kept");
    sq(8'd51); tick();
    chk(16'h001C, 8'd0,  "R9 second squash");

    ins(16'h0004, 8'd60); iss(16'h0004, 8'd60, 1'b1); tick();
    chk(16'h0004, 8'd60, "R11 insert beats issue");
    sq(8'd61); ins(16'h0004, 8'd70); tick();
    chk(16'h0004, 8'd0,  "R11 squash beats insert");
    clr = 1; ins(16'h0004, 8'd80); tick();
    chk(16'h0004, 8'd0,  "R11 clear beats insert");
    ins(16'h0004, 8'd81); tick();
    chk(16'h0004, 8'd0,  "R10 id entries cleared");
    ins(16'h0034, 8'd82); tick();
    chk(16'h001C, 8'd0,  "R10 all entries cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule